// File: doc/BRIEF.md
# Trusted-platform command-response buffer controller

This block is the register front end of a trusted-platform module that exchanges commands through a shared buffer. Software on a simple register bus claims a locality, wakes the module from idle, and rings a start doorbell once a command sits in the data buffer. It may ring a cancel doorbell while that command runs. The block turns an accepted start into a one-cycle request to a command engine. It clears the in-flight flag when the engine reports completion, and it latches a fatal status if that completion carried an error.

The address space is split into 4 KiB windows, one per locality. The window number of a write tells the block which locality is writing. Reads return the same registers in every window. A read is served from the aligned 32-bit word, shifted down by the byte offset, and trimmed to the access size. The block also reports fixed identification and the buffer geometry: the data buffer starts at a parameterised offset, and its size and address follow from the region size and the base address.

Top module: `cmdbuf_ctl`

## Requirements
- R1: After reset, the locality state word (0x00) reads 0x80 while the engine reports establishment, the locality status word (0x0C) and the start word (0x4C) read 0, the control status word (0x44) reads 0x2 (idle bit 1 set, fatal bit 0 clear), and `active_loc` is 0xFF.
- R2: Word 0x30 reads 0x00025811, built from type 1 in bits 3:0, version 1 in bits 7:4, transfer-size code 3 in bits 12:11, buffer-capable bit 14 and selector 1 in bits 18:17. Words 0x58 and 0x64 read REGION_BYTES-DBUF_OFF. Words 0x5C and 0x68 read BASE_ADDR+DBUF_OFF. Word 0x60 and unmapped words read 0.
- R3: A read of size code s (access bytes = s+1) at byte offset o = addr[1:0] returns the aligned word shifted right by 8*o, with every byte lane above lane s forced to 0. A write keeps only lanes 0..s of `bus_wdata` as its value.
- R4: Writing value 1 to offset 0x08 in window L sets locality-assigned (bit 1 of 0x00), writes L into the active field (bits 4:2 of 0x00), sets granted (bit 0 of 0x0C), clears seized (bit 1 of 0x0C), and makes `active_loc` equal L.
- R5: Writing value 2 to offset 0x08 clears locality-assigned and granted. `active_loc` then reads 0xFF. Values 4 and 8, or any value other than 1 and 2, change nothing.
- R6: Writing 1 to offset 0x40 clears the idle bit of 0x44. Writing 2 sets it. Other values have no effect.
- R7: Writing value 1 to offset 0x4C is accepted only if the start bit is clear, a locality is assigned, and the writer's window equals the active locality. An accepted write sets bit 0 of 0x4C and pulses `eng_req` high for exactly the next cycle. Any other start write changes nothing.
- R8: Writing value 1 to offset 0x48 while the start bit is set pulses `eng_cancel` for one cycle. Otherwise the write has no effect.
- R9: `eng_done` clears the start bit on the next edge. When `eng_err` accompanies it, bit 0 of 0x44 is set and stays set until reset.
- R10: Bit 0 of word 0x00 reads as the inverse of `eng_established`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 12+LOC_W | Byte address; bits above 11 select the locality window |
| bus_size | input | 2 | Access size code, bytes minus one |
| bus_wdata | input | 32 | Write value, least significant byte first |
| bus_rdata | output | 32 | Read value for the current address and size |
| eng_req | output | 1 | One-cycle command request to the engine |
| eng_cancel | output | 1 | One-cycle cancel request to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Error flag qualifying `eng_done` |
| eng_established | input | 1 | Engine establishment flag |
| active_loc | output | 8 | Active locality, 0xFF when none is assigned |

## Verification
Register reads use every byte offset and size code. This separates the shift from the lane trim, and it separates the identification and geometry constants from one another. Start writes come from the active window, from a foreign window, with no locality assigned, while a command is in flight, and as narrow writes whose dropped upper lanes decide whether the value equals 1. These cases tell the locality comparison, the busy check and the value mask apart. Completions with and without an error, cancels in both doorbell states, and the unused locality-control codes show whether each action is confined to its own condition.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
   localparam int WIN_BITS = 12;

   localparam logic [11:0] A_LSTATE = 12'h000;
   localparam logic [11:0] A_LCTRL  = 12'h008;
   localparam logic [11:0] A_LSTS   = 12'h00C;
   localparam logic [11:0] A_IFID   = 12'h030;
   localparam logic [11:0] A_CREQ   = 12'h040;
   localparam logic [11:0] A_CSTS   = 12'h044;
   localparam logic [11:0] A_CANCEL = 12'h048;
   localparam logic [11:0] A_START  = 12'h04C;
   localparam logic [11:0] A_CSIZE  = 12'h058;
   localparam logic [11:0] A_CADDR  = 12'h05C;
   localparam logic [11:0] A_RSIZE  = 12'h064;
   localparam logic [11:0] A_RADDR  = 12'h068;

   localparam logic [31:0] V_ONE = 32'd1;
   localparam logic [31:0] V_TWO = 32'd2;

   localparam logic [31:0] IFID_WORD = (32'd1 << 0) | (32'd1 << 4) | (32'd3 << 11)
                                     | (32'd1 << 14) | (32'd1 << 17);

   typedef struct packed {
      logic       assigned;
      logic [2:0] active;
      logic       granted;
      logic       seized;
   } loc_t;

   function automatic logic [31:0] lane_mask(input logic [1:0] sz);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 4; i++)
         if (i <= int'(sz)) m[i*8 +: 8] = 8'hFF;
      return m;
   endfunction
endpackage

// File: rtl/cmdbuf_locality.sv
module cmdbuf_locality
   import cmdbuf_pkg::*;
#(
   parameter int LOC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic [31:0]      wval,
   input  logic [LOC_W-1:0] wloc,
   output loc_t             loc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_q <= '0;
      end else if (ctrl_we) begin
         if (wval == V_ONE) begin
            loc_q.granted  <= 1'b1;
            loc_q.seized   <= 1'b0;
            loc_q.assigned <= 1'b1;
            loc_q.active   <= 3'(wloc);
         end else if (wval == V_TWO) begin
            loc_q.assigned <= 1'b0;
            loc_q.granted  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cmdbuf_doorbell.sv
module cmdbuf_doorbell
   import cmdbuf_pkg::*;
#(
   parameter int LOC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             creq_we,
   input  logic             cancel_we,
   input  logic             start_we,
   input  logic [31:0]      wval,
   input  logic [LOC_W-1:0] wloc,
   input  logic             loc_assigned,
   input  logic [2:0]       loc_active,
   input  logic             eng_done,
   input  logic             eng_err,
   output logic             start_busy,
   output logic             idle,
   output logic             fatal,
   output logic             eng_req,
   output logic             eng_cancel
);
   logic accept;
   logic ring_cancel;

   always_comb begin
      accept      = start_we && (wval == V_ONE) && !start_busy
                    && loc_assigned && (loc_active == 3'(wloc));
      ring_cancel = cancel_we && (wval == V_ONE) && start_busy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_busy <= 1'b0;
         idle       <= 1'b1;
         fatal      <= 1'b0;
         eng_req    <= 1'b0;
         eng_cancel <= 1'b0;
      end else begin
         eng_req    <= accept;
         eng_cancel <= ring_cancel;
         if (accept)        start_busy <= 1'b1;
         else if (eng_done) start_busy <= 1'b0;
         if (eng_done && eng_err) fatal <= 1'b1;
         if (creq_we) begin
            if (wval == V_ONE)      idle <= 1'b0;
            else if (wval == V_TWO) idle <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cmdbuf_rdmux.sv
module cmdbuf_rdmux
   import cmdbuf_pkg::*;
#(
   parameter logic [31:0] CMD_SIZE = 32'hF80,
   parameter logic [31:0] BUF_ADDR = 32'hFED4_0080
) (
   input  logic [11:0] raddr,
   input  logic [1:0]  rsize,
   input  loc_t        loc_q,
   input  logic        established,
   input  logic        start_busy,
   input  logic        idle,
   input  logic        fatal,
   output logic [31:0] rdata
);
   logic [31:0] word;
   logic [31:0] shifted;

   always_comb begin
      case (raddr[11:2])
         A_LSTATE[11:2]: word = {24'd0, 1'b1, 2'b00, loc_q.active, loc_q.assigned, !established};
         A_LSTS[11:2]:   word = {30'd0, loc_q.seized, loc_q.granted};
         A_IFID[11:2]:   word = IFID_WORD;
         A_CSTS[11:2]:   word = {30'd0, idle, fatal};
         A_START[11:2]:  word = {31'd0, start_busy};
         A_CSIZE[11:2]:  word = CMD_SIZE;
         A_CADDR[11:2]:  word = BUF_ADDR;
         A_RSIZE[11:2]:  word = CMD_SIZE;
         A_RADDR[11:2]:  word = BUF_ADDR;
         default:        word = '0;
      endcase
      shifted = word >> {raddr[1:0], 3'b000};
   end

   for (genvar b = 0; b < 4; b++) begin : g_lane
      assign rdata[b*8 +: 8] = (rsize >= 2'(b)) ? shifted[b*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/cmdbuf_ctl.sv
module cmdbuf_ctl
   import cmdbuf_pkg::*;
#(
   parameter int          LOC_W        = 3,
   parameter int          REGION_BYTES = 4096,
   parameter int          DBUF_OFF     = 128,
   parameter logic [31:0] BASE_ADDR    = 32'hFED4_0000,
   localparam int         ADDR_W       = WIN_BITS + LOC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              eng_req,
   output logic              eng_cancel,
   input  logic              eng_done,
   input  logic              eng_err,
   input  logic              eng_established,
   output logic [7:0]        active_loc
);
   localparam logic [31:0] CMD_SIZE = 32'(REGION_BYTES - DBUF_OFF);
   localparam logic [31:0] BUF_ADDR = BASE_ADDR + 32'(DBUF_OFF);

   if (LOC_W < 1 || LOC_W > 3) begin : g_bad_locw
      $error("LOC_W must lie in 1..3");
   end
   if (DBUF_OFF < 128 || DBUF_OFF >= REGION_BYTES || (DBUF_OFF % 4) != 0) begin : g_bad_dbuf
      $error("DBUF_OFF must be word aligned, at least 0x80 and inside the region");
   end
   if (REGION_BYTES > 4096) begin : g_bad_region
      $error("REGION_BYTES must fit one locality window");
   end

   logic [11:0]      off;
   logic [LOC_W-1:0] wloc;
   logic [31:0]      wval;
   loc_t             loc_q;
   logic             start_busy;
   logic             idle;
   logic             fatal;

   always_comb begin
      off  = bus_addr[11:0];
      wloc = bus_addr[ADDR_W-1:WIN_BITS];
      wval = bus_wdata & lane_mask(bus_size);
   end

   cmdbuf_locality #(.LOC_W(LOC_W)) u_loc (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (bus_we && off == A_LCTRL),
      .wval    (wval),
      .wloc    (wloc),
      .loc_q   (loc_q)
   );

   cmdbuf_doorbell #(.LOC_W(LOC_W)) u_bell (
      .clk          (clk),
      .rst_n        (rst_n),
      .creq_we      (bus_we && off == A_CREQ),
      .cancel_we    (bus_we && off == A_CANCEL),
      .start_we     (bus_we && off == A_START),
      .wval         (wval),
      .wloc         (wloc),
      .loc_assigned (loc_q.assigned),
      .loc_active   (loc_q.active),
      .eng_done     (eng_done),
      .eng_err      (eng_err),
      .start_busy   (start_busy),
      .idle         (idle),
      .fatal        (fatal),
      .eng_req      (eng_req),
      .eng_cancel   (eng_cancel)
   );

   cmdbuf_rdmux #(.CMD_SIZE(CMD_SIZE), .BUF_ADDR(BUF_ADDR)) u_rd (
      .raddr       (off),
      .rsize       (bus_size),
      .loc_q       (loc_q),
      .established (eng_established),
      .start_busy  (start_busy),
      .idle        (idle),
      .fatal       (fatal),
      .rdata       (bus_rdata)
   );

   assign active_loc = loc_q.assigned ? 8'(loc_q.active) : 8'hFF;
endmodule

// File: rtl/cmdbuf_ctl_chk.sv
module cmdbuf_ctl_chk #(
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              eng_req,
   input logic              eng_cancel,
   input logic              eng_done,
   input logic              start_busy,
   input logic              loc_assigned,
   input logic [7:0]        active_loc,
   input logic              fatal
);
   logic [11:0] aoff;
   assign aoff = bus_addr[11:0];

   assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |=> !eng_req);
   assert_req_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |-> ($past(bus_we) && $past(aoff) == 12'h04C && !$past(start_busy)));
   assert_req_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |-> start_busy);
   assert_cancel_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cancel |-> ($past(start_busy) && $past(bus_we) && $past(aoff) == 12'h048));
   assert_none_reads_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !loc_assigned |-> active_loc == 8'hFF);
   assert_active_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      loc_assigned |-> active_loc < 8'd8);
   assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && start_busy) |=> !start_busy);
   assert_fatal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fatal |=> fatal);
endmodule

bind cmdbuf_ctl cmdbuf_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_we       (bus_we),
   .bus_addr     (bus_addr),
   .eng_req      (eng_req),
   .eng_cancel   (eng_cancel),
   .eng_done     (eng_done),
   .start_busy   (start_busy),
   .loc_assigned (loc_q.assigned),
   .active_loc   (active_loc),
   .fatal        (fatal)
);

// File: tb/cmdbuf_ctl_tb.sv
`timescale 1ns/1ps
module cmdbuf_ctl_tb;
   localparam int AW = 15;
   localparam logic [31:0] GEO_SIZE = 32'hF80;
   localparam logic [31:0] GEO_ADDR = 32'hFED4_0080;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [1:0]    bus_size = 2'd3;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          eng_req, eng_cancel;
   logic          eng_done = 1'b0, eng_err = 1'b0, eng_established = 1'b1;
   logic [7:0]    active_loc;

   always #2.5 clk = ~clk;

   cmdbuf_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_req(eng_req), .eng_cancel(eng_cancel), .eng_done(eng_done),
      .eng_err(eng_err), .eng_established(eng_established), .active_loc(active_loc)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   bit       m_asg = 0, m_gnt = 0, m_sz = 0, m_idle = 1, m_fat = 0;
   bit       m_start = 0, m_req = 0, m_can = 0;
   bit [2:0] m_act = 0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] mread(logic [AW-1:0] a, logic [1:0] sz);
      logic [31:0] w, r;
      case (a[11:2])
         10'h000: w = {24'd0, 1'b1, 2'b00, m_act, m_asg, !eng_established};
         10'h003: w = {30'd0, m_sz, m_gnt};
         10'h00C: w = 32'h0002_5811;
         10'h011: w = {30'd0, m_idle, m_fat};
         10'h013: w = {31'd0, m_start};
         10'h016: w = GEO_SIZE;
         10'h017: w = GEO_ADDR;
         10'h019: w = GEO_SIZE;
         10'h01A: w = GEO_ADDR;
         default: w = 32'd0;
      endcase
      w = w >> (8 * int'(a[1:0]));
      r = 32'd0;
      for (int i = 0; i <= int'(sz); i++) r[i*8 +: 8] = w[i*8 +: 8];
      return r;
   endfunction

   task automatic model_edge();
      logic [31:0] v;
      logic [11:0] o;
      logic [2:0]  wl;
      bit acc;
      v = 32'd0;
      for (int i = 0; i <= int'(bus_size); i++) v[i*8 +: 8] = bus_wdata[i*8 +: 8];
      o = bus_addr[11:0];
      wl = bus_addr[14:12];
      acc = bus_we && o == 12'h04C && v == 1 && !m_start && m_asg && m_act == wl;
      m_req = acc;
      m_can = bus_we && o == 12'h048 && v == 1 && m_start;
      if (acc) m_start = 1;
      else if (eng_done) m_start = 0;
      if (eng_done && eng_err) m_fat = 1;
      if (bus_we && o == 12'h008) begin
         if (v == 1) begin m_gnt = 1; m_sz = 0; m_asg = 1; m_act = wl; end
         else if (v == 2) begin m_asg = 0; m_gnt = 0; end
      end
      if (bus_we && o == 12'h040) begin
         if (v == 1) m_idle = 0;
         else if (v == 2) m_idle = 1;
      end
   endtask

   task automatic cyc(bit we, logic [AW-1:0] a, logic [1:0] sz, logic [31:0] wd,
                      bit dn, bit er, string tag);
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
      eng_done = dn; eng_err = er;
      #1;
      check({tag, " rdata"}, bus_rdata, mread(a, sz));
      @(posedge clk);
      model_edge();
      #1;
      check("R7 eng_req", {31'd0, eng_req}, {31'd0, m_req});
      check("R8 eng_cancel", {31'd0, eng_cancel}, {31'd0, m_can});
      check("R4 active_loc", {24'd0, active_loc}, m_asg ? {29'd0, m_act} : 32'hFF);
   endtask

   task automatic rd(logic [AW-1:0] a, logic [1:0] sz, string tag);
      cyc(0, a, sz, 32'd0, 0, 0, tag);
   endtask
   task automatic wr(logic [AW-1:0] a, logic [1:0] sz, logic [31:0] d, string tag);
      cyc(1, a, sz, d, 0, 0, tag);
   endtask

   initial begin
      #500000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values
      rd(15'h0000, 3, "R1 lstate");
      rd(15'h000C, 3, "R1 lsts");
      rd(15'h0044, 3, "R1 csts");
      rd(15'h004C, 3, "R1 start");
      // R2 identification and geometry
      rd(15'h0030, 3, "R2 ifid");
      rd(15'h0058, 3, "R2 csize");
      rd(15'h505C, 3, "R2 caddr");
      rd(15'h0060, 3, "R2 chigh");
      rd(15'h0064, 3, "R2 rsize");
      rd(15'h0068, 3, "R2 raddr");
      rd(15'h0034, 3, "R2 unmapped");
      // R3 byte shift and lane trim
      for (int o = 0; o < 4; o++)
         for (int s = 0; s < 4; s++) begin
            rd(15'(12'h030 + o), 2'(s), "R3 ifid lanes");
            rd(15'(12'h05C + o), 2'(s), "R3 caddr lanes");
         end
      // R10 established flag inverted into bit 0
      eng_established = 1'b0;
      rd(15'h0000, 3, "R10 est low");
      eng_established = 1'b1;
      rd(15'h0000, 0, "R10 est high");
      // R7 start without an assigned locality is refused
      wr(15'h004C, 3, 32'd1, "R7 no locality");
      rd(15'h004C, 3, "R7 start idle");
      // R4 request from window 2
      wr(15'h2008, 3, 32'd1, "R4 request");
      rd(15'h0000, 3, "R4 lstate");
      rd(15'h000C, 3, "R4 lsts");
      // R8 cancel with nothing running
      wr(15'h2048, 3, 32'd1, "R8 cancel idle");
      // R7 foreign window refused, narrow write with dropped lane
      wr(15'h104C, 3, 32'd1, "R7 foreign");
      wr(15'h204C, 1, 32'h0000_0101, "R7 value 0x101");
      wr(15'h204C, 0, 32'h0000_0101, "R3 R7 byte write");
      rd(15'h204C, 3, "R7 busy");
      wr(15'h204C, 3, 32'd1, "R7 in flight");
      wr(15'h3048, 3, 32'd1, "R8 cancel busy");
      wr(15'h2048, 3, 32'd3, "R8 cancel wrong value");
      cyc(0, 15'h004C, 3, 32'd0, 1, 0, "R9 done ok");
      rd(15'h004C, 3, "R9 cleared");
      rd(15'h0044, 3, "R9 no fatal");
      // R6 idle control
      wr(15'h0040, 3, 32'd1, "R6 ready");
      rd(15'h0044, 3, "R6 not idle");
      wr(15'h0040, 3, 32'd3, "R6 other");
      rd(15'h0044, 3, "R6 held");
      wr(15'h0040, 3, 32'd2, "R6 go idle");
      rd(15'h0044, 3, "R6 idle");
      // R5 unused locality codes
      wr(15'h6008, 3, 32'd4, "R5 seize code");
      wr(15'h6008, 3, 32'd8, "R5 est code");
      rd(15'h0000, 3, "R5 unchanged");
      // R9 error completion is sticky
      wr(15'h204C, 3, 32'd1, "R7 second start");
      cyc(0, 15'h0044, 3, 32'd0, 1, 1, "R9 done err");
      rd(15'h0044, 3, "R9 fatal");
      rd(15'h0044, 3, "R9 fatal held");
      // R5 relinquish
      wr(15'h0008, 3, 32'd2, "R5 relinquish");
      rd(15'h0000, 3, "R5 lstate");
      rd(15'h000C, 3, "R5 lsts");
      wr(15'h204C, 3, 32'd1, "R7 after release");
      // R4 new owner in window 7, R7 start accepted there
      wr(15'h7008, 0, 32'hFFFF_FF01, "R4 request w7");
      wr(15'h704C, 3, 32'd1, "R7 start w7");
      rd(15'h704C, 3, "R7 busy w7");
      cyc(0, 15'h0000, 3, 32'd0, 1, 0, "R9 done w7");
      rd(15'h004C, 3, "R9 clear w7");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule